// File: doc/BRIEF.md
# Polled Real-Time Cycle Scheduler

This block is the master-side sequencer for a time-slotted, polled industrial Ethernet network. A free-running timer marks out cycles of fixed length. At every cycle boundary the scheduler asks the transmitter for a start-of-cycle frame. It then walks the configured controlled nodes and asks for one poll request per node. After each request it holds off until that node's response arrives or a programmable timeout expires. Last, it asks for an asynchronous-grant frame that names one station. Only one station ever transmits: no request is issued while a response window is open.

Slow nodes are polled only on some cycles. Each node has its own period N and slot offset, and a per-node phase counter selects whether the node is polled in this cycle. In chained mode the individual polls are replaced by one broadcast request, followed by a fixed collection window in which every selected node answers. Frame building, the MAC and everything below it are outside the block. The transmitter is a valid/ready sink. The receiver is a valid/ready source whose responses are accepted only while a response window is open.

Back-pressure rules: a frame request (`tx_valid` with `tx_type` and `tx_node`) stays asserted and unchanged until `tx_ready` is seen high at a clock edge. The one exception is a cycle overrun, where the pending request is withdrawn and replaced by the new start frame. `rx_ready` is high only inside a response window. A response offered while it is low is not consumed and has no effect.

Top module: `poll_cycle_sched`

## Requirements
- R1: While reset is held, `tx_valid`, `rx_ready`, `miss` and `overrun` are all zero.
- R2: A start frame request (type code 1, node field all ones) appears one clock after every timer wrap. Successive start requests rise exactly `cfg_cycle_len` clocks apart, and the first one comes on the first clock after reset is released.
- R3: In standard mode, after the start frame is accepted, one poll request (type code 2, node field = that node's ID) is issued for each node selected in this cycle, in ascending node index order, and no others.
- R4: No frame request is presented while `rx_ready` is high; `rx_ready` is high only during a response window.
- R5: During a poll's response window, a response whose ID equals the polled node's ID ends the window and clears that node's `miss` bit. Responses carrying any other ID are ignored.
- R6: If no matching response arrives, the window ends after exactly `cfg_resp_to` clocks. The node's `miss` bit is set, and the next request appears on the following clock.
- R7: Node k is selected in cycle c (c counted from 0 after reset) when it is enabled and either its period N_k is 0 or 1, or c mod N_k equals its offset. Disabled nodes are never polled.
- R8: In chained mode one broadcast request (type code 4, node field all ones) replaces the polls. Over the next `cfg_chain_wait` clocks, responses from any selected node are collected. Each selected node's `miss` bit then shows whether it answered.
- R9: Every completed cycle ends with one asynchronous-grant request (type code 3, node field = `cfg_async_id`), after which no request is made until the next start frame.
- R10: If a cycle's sequence has not finished at the timer wrap, `overrun` is set for the next cycle, the pending request is withdrawn and the start frame is still requested on time. `overrun` changes only at a timer wrap.
- R11: A request that is not accepted stays asserted with the same type and node until accepted, unless an overrun replaces it with a start frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cycle_len | input | TMR_W | Cycle length in clocks |
| cfg_chain | input | 1 | Chained mode, sampled at each cycle start |
| cfg_node_en | input | NODES | Per-node enable |
| cfg_node_id | input | NODES*ID_W | Per-node network ID, node k in bits k*ID_W up |
| cfg_mux_n | input | NODES*MUX_W | Per-node polling period (0 or 1 means every cycle) |
| cfg_mux_off | input | NODES*MUX_W | Per-node slot offset within its period |
| cfg_resp_to | input | TO_W | Response timeout in clocks |
| cfg_chain_wait | input | TO_W | Collection window after a chained broadcast, clocks |
| cfg_async_id | input | ID_W | Station granted the asynchronous slot |
| tx_valid | output | 1 | Frame request valid |
| tx_ready | input | 1 | Transmitter accepts the request |
| tx_type | output | 3 | Frame type: 1 start, 2 poll, 3 async grant, 4 chained broadcast |
| tx_node | output | ID_W | Target node ID (all ones for broadcast) |
| rx_valid | input | 1 | Response received |
| rx_node | input | ID_W | ID of the responding node |
| rx_ready | output | 1 | Response window open |
| miss | output | NODES | Per-node missed-response flags |
| overrun | output | 1 | Previous cycle did not finish in time |

## Verification
The checker watches, on every clock, that a start request follows each timer wrap and that requests and response windows never overlap. It also checks that stalled requests hold still unless a wrap intervenes, that only legal type codes appear, and that the overrun flag moves only at a wrap. Which nodes get polled, their order under the multiplexed schedule, and the resulting miss flags can only be shown by the bench's cycle scenarios. The same holds for exact timeout lengths, stray responses being ignored, chained-mode collection and overrun recovery. The bench compares these against its own schedule model under random back-pressure.

// File: rtl/sched_pkg.sv
`timescale 1ns/1ps
package sched_pkg;
  typedef enum logic [2:0] {
    FT_NONE  = 3'd0,
    FT_SOC   = 3'd1,
    FT_PREQ  = 3'd2,
    FT_SOA   = 3'd3,
    FT_CHAIN = 3'd4
  } frame_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SOC,
    ST_PREQ,
    ST_WAIT,
    ST_CHAIN,
    ST_CWAIT,
    ST_SOA
  } sched_st_t;
endpackage

// File: rtl/cycle_timer.sv
`timescale 1ns/1ps
module cycle_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMR_W-1:0] len,
  output logic             tick
);
  logic [TMR_W-1:0] tmr;
  logic [TMR_W:0]   tmr_nx;

  assign tmr_nx = {1'b0, tmr} + (TMR_W+1)'(1);
  assign tick   = (tmr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr <= '0;
    else if (tmr_nx >= {1'b0, len}) tmr <= '0;
    else tmr <= tmr_nx[TMR_W-1:0];
  end
endmodule

// File: rtl/mux_slot_sel.sv
`timescale 1ns/1ps
module mux_slot_sel #(
  parameter int NODES = 4,
  parameter int MUX_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic [NODES-1:0]       en,
  input  logic [NODES*MUX_W-1:0] per_flat,
  input  logic [NODES*MUX_W-1:0] off_flat,
  output logic [NODES-1:0]       sel
);
  for (genvar k = 0; k < NODES; k++) begin : g_node
    logic [MUX_W-1:0] ph;
    logic [MUX_W-1:0] per;
    logic [MUX_W-1:0] off;
    logic [MUX_W:0]   ph_nx;
    logic             every;

    assign per    = per_flat[k*MUX_W +: MUX_W];
    assign off    = off_flat[k*MUX_W +: MUX_W];
    assign every  = (per <= MUX_W'(1));
    assign ph_nx  = {1'b0, ph} + (MUX_W+1)'(1);
    assign sel[k] = en[k] && (every || (ph == off));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph <= '0;
      else if (tick) begin
        if (every || (ph_nx >= {1'b0, per})) ph <= '0;
        else ph <= ph_nx[MUX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/lowest_pick.sv
`timescale 1ns/1ps
module lowest_pick #(
  parameter int NODES = 4,
  parameter int IDX_W = 2
) (
  input  logic [NODES-1:0] req,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    idx = '0;
    for (int k = NODES - 1; k >= 0; k--) begin
      if (req[k]) idx = IDX_W'(k);
    end
  end
  assign any = |req;
endmodule

// File: rtl/poll_cycle_sched.sv
`timescale 1ns/1ps
module poll_cycle_sched
  import sched_pkg::*;
#(
  parameter int NODES = 4,
  parameter int ID_W  = 8,
  parameter int TMR_W = 16,
  parameter int MUX_W = 4,
  parameter int TO_W  = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [TMR_W-1:0]       cfg_cycle_len,
  input  logic                   cfg_chain,
  input  logic [NODES-1:0]       cfg_node_en,
  input  logic [NODES*ID_W-1:0]  cfg_node_id,
  input  logic [NODES*MUX_W-1:0] cfg_mux_n,
  input  logic [NODES*MUX_W-1:0] cfg_mux_off,
  input  logic [TO_W-1:0]        cfg_resp_to,
  input  logic [TO_W-1:0]        cfg_chain_wait,
  input  logic [ID_W-1:0]        cfg_async_id,
  output logic                   tx_valid,
  input  logic                   tx_ready,
  output logic [2:0]             tx_type,
  output logic [ID_W-1:0]        tx_node,
  input  logic                   rx_valid,
  input  logic [ID_W-1:0]        rx_node,
  output logic                   rx_ready,
  output logic [NODES-1:0]       miss,
  output logic                   overrun
);
  localparam int IDX_W = (NODES > 1) ? $clog2(NODES) : 1;

  sched_st_t        state;
  logic [NODES-1:0] pend;
  logic [NODES-1:0] got;
  logic [NODES-1:0] miss_q;
  logic [NODES-1:0] sel;
  logic [NODES-1:0] hit_vec;
  logic [NODES-1:0] rest;
  logic [TO_W-1:0]  cnt;
  logic [TO_W:0]    cnt_nx;
  logic [IDX_W-1:0] cur;
  logic             any;
  logic             chain_q;
  logic             ovr_q;
  logic             tick;
  logic             hit_cur;
  logic             resp_end;
  logic             chain_end;
  logic [ID_W-1:0]  ids [NODES];
  frame_t           ftype;

  for (genvar k = 0; k < NODES; k++) begin : g_id
    assign ids[k]     = cfg_node_id[k*ID_W +: ID_W];
    assign hit_vec[k] = rx_valid && (rx_node == ids[k]) && pend[k];
  end

  cycle_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .len(cfg_cycle_len), .tick(tick)
  );

  mux_slot_sel #(.NODES(NODES), .MUX_W(MUX_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(cfg_node_en),
    .per_flat(cfg_mux_n), .off_flat(cfg_mux_off), .sel(sel)
  );

  lowest_pick #(.NODES(NODES), .IDX_W(IDX_W)) u_pick (
    .req(pend), .idx(cur), .any(any)
  );

  assign cnt_nx    = {1'b0, cnt} + (TO_W+1)'(1);
  assign resp_end  = (cnt_nx >= {1'b0, cfg_resp_to});
  assign chain_end = (cnt_nx >= {1'b0, cfg_chain_wait});
  assign hit_cur   = hit_vec[cur];
  assign rest      = pend & ~(NODES'(1) << cur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pend    <= '0;
      got     <= '0;
      miss_q  <= '0;
      cnt     <= '0;
      chain_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else if (tick) begin
      state   <= ST_SOC;
      pend    <= sel;
      chain_q <= cfg_chain;
      ovr_q   <= (state != ST_IDLE);
    end else begin
      unique case (state)
        ST_SOC: if (tx_ready) begin
          cnt <= '0;
          got <= '0;
          if (!any) state <= ST_SOA;
          else if (chain_q) state <= ST_CHAIN;
          else state <= ST_PREQ;
        end
        ST_PREQ: if (tx_ready) begin
          state <= ST_WAIT;
          cnt   <= '0;
        end
        ST_WAIT: begin
          if (hit_cur || resp_end) begin
            miss_q[cur] <= !hit_cur;
            pend[cur]   <= 1'b0;
            state       <= (|rest) ? ST_PREQ : ST_SOA;
          end else begin
            cnt <= cnt_nx[TO_W-1:0];
          end
        end
        ST_CHAIN: if (tx_ready) begin
          state <= ST_CWAIT;
          cnt   <= '0;
        end
        ST_CWAIT: begin
          got <= got | hit_vec;
          if (chain_end) begin
            for (int k = 0; k < NODES; k++) begin
              if (pend[k]) miss_q[k] <= !(got[k] || hit_vec[k]);
            end
            pend  <= '0;
            state <= ST_SOA;
          end else begin
            cnt <= cnt_nx[TO_W-1:0];
          end
        end
        ST_SOA: if (tx_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ftype   = FT_NONE;
    tx_node = '0;
    unique case (state)
      ST_SOC:   begin ftype = FT_SOC;   tx_node = '1;           end
      ST_PREQ:  begin ftype = FT_PREQ;  tx_node = ids[cur];     end
      ST_CHAIN: begin ftype = FT_CHAIN; tx_node = '1;           end
      ST_SOA:   begin ftype = FT_SOA;   tx_node = cfg_async_id; end
      default:  begin ftype = FT_NONE;  tx_node = '0;           end
    endcase
  end

  assign tx_valid = (ftype != FT_NONE);
  assign tx_type  = ftype;
  assign rx_ready = (state == ST_WAIT) || (state == ST_CWAIT);
  assign miss     = miss_q;
  assign overrun  = ovr_q;
endmodule

// File: rtl/sched_chk.sv
`timescale 1ns/1ps
module sched_chk #(
  parameter int ID_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick,
  input logic            tx_valid,
  input logic            tx_ready,
  input logic [2:0]      tx_type,
  input logic [ID_W-1:0] tx_node,
  input logic            rx_ready,
  input logic            overrun
);
  // R2
  soc_after_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (tx_valid && tx_type == 3'd1 && tx_node == {ID_W{1'b1}}));

  // R4
  single_talker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && rx_ready));

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !tick) |=> (tx_valid && $stable(tx_type) && $stable(tx_node)));

  // R10
  ovr_wrap_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(overrun));

  // R3
  legal_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_type >= 3'd1 && tx_type <= 3'd4));
endmodule

bind poll_cycle_sched sched_chk #(.ID_W(ID_W)) u_sched_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_type(tx_type), .tx_node(tx_node),
  .rx_ready(rx_ready), .overrun(overrun)
);

// File: tb/poll_cycle_sched_test.sv
`timescale 1ns/1ps
module poll_cycle_sched_test;
  localparam int NODES = 4, ID_W = 8, TMR_W = 16, MUX_W = 4, TO_W = 12;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                   rst_n;
  logic [TMR_W-1:0]       cfg_cycle_len;
  logic                   cfg_chain;
  logic [NODES-1:0]       cfg_node_en;
  logic [NODES*ID_W-1:0]  cfg_node_id;
  logic [NODES*MUX_W-1:0] cfg_mux_n, cfg_mux_off;
  logic [TO_W-1:0]        cfg_resp_to, cfg_chain_wait;
  logic [ID_W-1:0]        cfg_async_id;
  logic                   tx_valid, tx_ready, rx_valid, rx_ready, overrun;
  logic [2:0]             tx_type;
  logic [ID_W-1:0]        tx_node, rx_node;
  logic [NODES-1:0]       miss;

  poll_cycle_sched #(.NODES(NODES), .ID_W(ID_W), .TMR_W(TMR_W), .MUX_W(MUX_W), .TO_W(TO_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_cycle_len(cfg_cycle_len), .cfg_chain(cfg_chain),
    .cfg_node_en(cfg_node_en), .cfg_node_id(cfg_node_id), .cfg_mux_n(cfg_mux_n),
    .cfg_mux_off(cfg_mux_off), .cfg_resp_to(cfg_resp_to), .cfg_chain_wait(cfg_chain_wait),
    .cfg_async_id(cfg_async_id), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_type(tx_type), .tx_node(tx_node), .rx_valid(rx_valid), .rx_node(rx_node),
    .rx_ready(rx_ready), .miss(miss), .overrun(overrun)
  );

  int checks = 0, errors = 0;
  int cyc_idx, lst_n, pos, done_cyc, soc_gap, wait_steps, ready_pct;
  int lst [NODES];
  int cdly [NODES];
  bit resp_en [NODES];
  bit in_cyc, exp_chain, prev_soc, prev_hold, ovr_mode;
  logic [2:0] prev_type;
  logic [ID_W-1:0] prev_node;
  logic [NODES-1:0] exp_miss;

  function automatic logic [ID_W-1:0] nid(int k);
    return ID_W'(8'h11 * (k + 1));
  endfunction

  function automatic bit sel_f(int c, int k);
    int n, o;
    n = int'(cfg_mux_n[k*MUX_W +: MUX_W]);
    o = int'(cfg_mux_off[k*MUX_W +: MUX_W]);
    if (!cfg_node_en[k]) return 1'b0;
    if (n <= 1) return 1'b1;
    return (c % n) == o;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step();
    bit fired;
    bit hs;
    int k;
    @(negedge clk);
    if (prev_hold)
      chk(tx_valid && ((tx_type == prev_type && tx_node == prev_node) || tx_type == 3'd1),
          "R11", "stalled request changed", int'(tx_type), int'(prev_type));
    if (tx_valid && tx_type == 3'd1 && !prev_soc) begin
      if (soc_gap >= 0) chk(soc_gap == int'(cfg_cycle_len), "R2", "start spacing", soc_gap, int'(cfg_cycle_len));
      chk(tx_node == '1, "R2", "start node field", int'(tx_node), 255);
      soc_gap = 0;
    end
    if (soc_gap >= 0) soc_gap++;
    prev_soc = tx_valid && tx_type == 3'd1;
    if (rx_ready) chk(!tx_valid, "R4", "request during response window", int'(tx_valid), 0);
    if (wait_steps >= 0) begin
      wait_steps++;
      if (tx_valid) begin
        chk(wait_steps == int'(cfg_resp_to) + 1, "R6", "timeout length", wait_steps, int'(cfg_resp_to) + 1);
        wait_steps = -1;
      end
    end
    // response driver
    fired = 1'b0;
    rx_valid = 1'b0;
    for (int i = 0; i < NODES; i++) begin
      if (!fired && cdly[i] == 0 && rx_ready) begin
        rx_valid = 1'b1; rx_node = nid(i); cdly[i] = -1; fired = 1'b1;
      end
    end
    if (!fired && rx_ready && ($urandom % 4) == 0) begin
      rx_valid = 1'b1; rx_node = 8'hF0;   // stray ID, must be ignored (R5)
    end
    for (int i = 0; i < NODES; i++) if (cdly[i] > 0) cdly[i]--;
    tx_ready = int'($urandom % 100) < ready_pct;
    hs = tx_valid && tx_ready;
    prev_hold = tx_valid && !tx_ready;
    prev_type = tx_type;
    prev_node = tx_node;
    if (hs && !ovr_mode) begin
      case (tx_type)
        3'd1: begin
          chk(!in_cyc, "R9", "cycle left open at start", int'(in_cyc), 0);
          in_cyc = 1'b1; cyc_idx++; lst_n = 0; pos = 0; exp_chain = cfg_chain;
          for (int i = 0; i < NODES; i++) if (sel_f(cyc_idx, i)) begin lst[lst_n] = i; lst_n++; end
        end
        3'd2: begin
          chk(!exp_chain, "R8", "poll issued in chained mode", 1, 0);
          if (pos < lst_n) begin
            k = lst[pos];
            chk(tx_node == nid(k), "R3", "poll target", int'(tx_node), int'(nid(k)));
            pos++;
            if (resp_en[k]) cdly[k] = 1 + int'($urandom % (int'(cfg_resp_to) - 2));
            else wait_steps = 0;
          end else chk(1'b0, "R7", "unexpected extra poll", pos, lst_n);
        end
        3'd4: begin
          chk(exp_chain && lst_n > 0, "R8", "unexpected broadcast", int'(exp_chain), 1);
          chk(tx_node == '1, "R8", "broadcast node field", int'(tx_node), 255);
          for (int i = 0; i < lst_n; i++) if (resp_en[lst[i]]) cdly[lst[i]] = 2 + 3 * lst[i];
          pos = lst_n;
        end
        3'd3: begin
          chk(tx_node == cfg_async_id, "R9", "grant target", int'(tx_node), int'(cfg_async_id));
          chk(pos == lst_n, "R7", "polled node count", pos, lst_n);
          for (int i = 0; i < lst_n; i++) exp_miss[lst[i]] = !resp_en[lst[i]];
          chk(miss == exp_miss, "R5", "miss flags (R6 R8)", int'(miss), int'(exp_miss));
          chk(overrun == 1'b0, "R10", "overrun on in-time cycle", int'(overrun), 0);
          in_cyc = 1'b0; done_cyc++;
        end
        default: chk(1'b0, "R3", "bad type", int'(tx_type), 1);
      endcase
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tx_ready = 1'b0; rx_valid = 1'b0; rx_node = '0;
    cyc_idx = -1; lst_n = 0; pos = 0; done_cyc = 0; soc_gap = -1; wait_steps = -1;
    in_cyc = 0; prev_soc = 0; prev_hold = 0; exp_miss = '0;
    for (int i = 0; i < NODES; i++) cdly[i] = -1;
    repeat (3) @(negedge clk);
    chk(!tx_valid && !rx_ready, "R1", "request/window in reset", int'(tx_valid), 0);
    chk(miss == '0 && !overrun, "R1", "flags in reset", int'(miss), 0);
    rst_n = 1'b1;
  endtask

  task automatic run(int ncyc);
    int guard;
    do_reset();
    guard = 0;
    while (done_cyc < ncyc && guard < ncyc * int'(cfg_cycle_len) + 500) begin
      step(); guard++;
    end
    chk(done_cyc >= ncyc, "R9", "cycles completed", done_cyc, ncyc);
  endtask

  task automatic set_mux(int k, int n, int o);
    cfg_mux_n[k*MUX_W +: MUX_W]   = MUX_W'(n);
    cfg_mux_off[k*MUX_W +: MUX_W] = MUX_W'(o);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R9", "watchdog expired", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'h5EED_0B0B));
    for (int i = 0; i < NODES; i++) cfg_node_id[i*ID_W +: ID_W] = nid(i);
    cfg_cycle_len = 16'd220; cfg_resp_to = 12'd10; cfg_chain_wait = 12'd16;
    cfg_async_id = 8'h5A; ready_pct = 75; ovr_mode = 0;

    // directed: all nodes every cycle, mixed responders (R3 R5 R6)
    cfg_chain = 0; cfg_node_en = 4'hF;
    for (int i = 0; i < NODES; i++) begin set_mux(i, 1, 0); resp_en[i] = (i != 2); end
    run(4);

    // directed: multiplexed schedule (R7)
    set_mux(0, 1, 0); set_mux(1, 2, 1); set_mux(2, 3, 2); set_mux(3, 0, 0);
    cfg_node_en = 4'b1011;
    for (int i = 0; i < NODES; i++) resp_en[i] = 1'b1;
    run(7);

    // directed: chained mode (R8)
    cfg_chain = 1; cfg_node_en = 4'hF;
    for (int i = 0; i < NODES; i++) begin set_mux(i, 1, 0); resp_en[i] = (i != 1); end
    run(3);

    // directed: no node enabled, start then grant only (R9)
    cfg_chain = 0; cfg_node_en = 4'h0;
    run(2);

    // random scenarios
    for (int s = 0; s < 8; s++) begin
      cfg_chain = 1'($urandom % 2);
      cfg_resp_to = TO_W'(8 + $urandom % 6);
      cfg_async_id = ID_W'($urandom);
      for (int i = 0; i < NODES; i++) begin
        cfg_node_en[i] = ($urandom % 4) != 0;
        n = int'($urandom % 5);
        set_mux(i, n, (n > 1) ? int'($urandom % n) : 0);
        resp_en[i] = ($urandom % 3) != 0;
      end
      run(10);
    end

    // directed: overrun and recovery (R10)
    ovr_mode = 1; ready_pct = 100; cfg_chain = 0; cfg_node_en = 4'hF;
    cfg_cycle_len = 16'd40; cfg_resp_to = 12'd20;
    for (int i = 0; i < NODES; i++) begin set_mux(i, 1, 0); resp_en[i] = 1'b0; end
    do_reset();
    repeat (100) step();
    chk(overrun == 1'b1, "R10", "overrun after late cycle", int'(overrun), 1);
    cfg_resp_to = 12'd3;
    repeat (100) step();
    chk(overrun == 1'b0, "R10", "overrun cleared after in-time cycle", int'(overrun), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule